// File: doc/BRIEF.md
# Ten-Bit PWM Generator with Coarse Period Setting

This block drives one pulse-width-modulated output from the system clock. An internal 10-bit counter steps once per clock. The period is set by an 8-bit value. The hardware appends two constant one bits to that value to form the counter's last count, so one period lasts 4·(P+1) clocks. The duty value has the full 10 bits. Its upper eight bits and its lower two bits arrive on separate inputs, and it is compared in the same count units as the counter. The duty ratio is therefore D / (4·(P+1)). Fine duty resolution is lost as the period is shortened: P = 0x3F gives 256 steps and P = 0xFF gives 1024 steps.

The period and duty inputs are sampled into active settings only when a new period begins. Software can therefore change them at any time without producing a torn cycle. A one-clock strobe marks the first count of every period. Dropping the enable parks the block with its output low. Raising it again starts a fresh period at once.

Top module: `pwm10_gen`

## Requirements
- R1: With the block enabled, wrap_o pulses exactly once every 4·(P+1) clocks, where P is the active period setting (P = 0 gives 4 clocks, P = 0xFF gives 1024 clocks).
- R2: The duty count is D = {duty_hi_i, duty_lo_i}, with duty_hi_i as bits 9..2 and duty_lo_i as bits 1..0. When 0 < D < 4·(P+1), pwm_o is high for the first D clocks of each period, beginning on the cycle wrap_o is high, and low for the rest of the period.
- R3: When D ≥ 4·(P+1), pwm_o stays high through the whole period, with no low cycle at the period boundary.
- R4: When D = 0, pwm_o stays low for the whole period.
- R5: The period and duty inputs are captured only on the first clock of a period. Changes made in mid-period do not alter the period in progress and take effect from the next one.
- R6: wrap_o is high for exactly one clock per period, on the cycle the count is 0.
- R7: While en_i is low, pwm_o and wrap_o are low and the counter is held. On the first clock edge with en_i high, a new period starts: wrap_o pulses and the settings present on the inputs are captured.
- R8: Synchronous active-high reset drives pwm_o and wrap_o low and clears the counter and the active settings.
- R9: With P = 0x3F, duty_hi_i = 0x10 and duty_lo_i = 0, the period is 256 clocks and pwm_o is high for 64 of them (25 %).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low parks the output low |
| period_i | input | PER_W | Coarse period setting P |
| duty_hi_i | input | PER_W | Upper duty bits |
| duty_lo_i | input | 2 | Lower two duty bits |
| pwm_o | output | 1 | Registered PWM output |
| wrap_o | output | 1 | Registered one-clock period-start strobe |

## Verification
A counter that runs past its last count, or settings captured at the wrong moment, change the spacing of the wrap_o pulses. This becomes visible within one period, at most 1024 clocks. A wrong active duty value shows at the first compare edge of the following period, as a pwm_o high time that differs from the D expected for that period. Captures in mid-period are tested by changing the inputs partway through a period and measuring the high time and length of that period and of the next one. A disable fault shows on the first clock after en_i falls, as pwm_o or wrap_o high while the block is parked.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  // Count bits below the period setting; one period = 2**SCALE_BITS * (P+1) clocks.
  localparam int unsigned SCALE_BITS = 2;
endpackage

// File: rtl/pwm10_settings.sv
module pwm10_settings
  import pwm10_pkg::*;
#(
  parameter int unsigned PER_W = 8,
  localparam int unsigned CNT_W = PER_W + SCALE_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic [PER_W-1:0]      period_i,
  input  logic [PER_W-1:0]      duty_hi_i,
  input  logic [SCALE_BITS-1:0] duty_lo_i,
  output logic [CNT_W-1:0]      last_o,
  output logic [CNT_W-1:0]      duty_nx_o
);
  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] duty_in;

  assign duty_in   = {duty_hi_i, duty_lo_i};
  assign duty_nx_o = load_i ? duty_in : duty_q;
  assign last_o    = {per_q, {SCALE_BITS{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= '0;
      duty_q <= '0;
    end else if (load_i) begin
      per_q  <= period_i;
      duty_q <= duty_in;
    end
  end

  // R5: active settings frozen between period starts
  a_r5_hold_between_wraps: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(per_q) && $stable(duty_q)));
  // R5: a capture takes the values present at the period start
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (per_q == $past(period_i)));
endmodule

// File: rtl/pwm10_counter.sv
module pwm10_counter
  import pwm10_pkg::*;
#(
  parameter int unsigned PER_W = 8,
  localparam int unsigned CNT_W = PER_W + SCALE_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             restart;

  assign restart  = !run_q || (cnt_q == last_i);
  assign load_o   = en_i && restart;
  assign cnt_nx_o = (!en_i || restart) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx_o;
      run_q <= en_i;
    end
  end

  // R1: count never leaves the active period
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_i);
  // R7: disabled counter parks at zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm10_compare.sv
module pwm10_compare
  import pwm10_pkg::*;
#(
  parameter int unsigned PER_W = 8,
  localparam int unsigned CNT_W = PER_W + SCALE_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_nx_i,
  input  logic [CNT_W-1:0] duty_nx_i,
  output logic             pwm_o,
  output logic             wrap_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o  <= 1'b0;
      wrap_o <= 1'b0;
    end else begin
      pwm_o  <= en_i && (cnt_nx_i < duty_nx_i);
      wrap_o <= load_i;
    end
  end

  // R6: strobe lasts a single clock
  a_r6_wrap_single: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);
  // R7: parked block keeps both outputs low
  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!pwm_o && !wrap_o));
  // R4: zero duty never raises the output
  a_r4_zero_low: assert property (@(posedge clk) disable iff (rst)
    (duty_nx_i == '0) |=> !pwm_o);
  // R2: output is high on a period start whenever duty is nonzero
  a_r2_start_high: assert property (@(posedge clk) disable iff (rst)
    (load_i && duty_nx_i != '0) |=> (pwm_o && wrap_o));
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int unsigned PER_W = 8,
  localparam int unsigned CNT_W = PER_W + SCALE_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en_i,
  input  logic [PER_W-1:0]      period_i,
  input  logic [PER_W-1:0]      duty_hi_i,
  input  logic [SCALE_BITS-1:0] duty_lo_i,
  output logic                  pwm_o,
  output logic                  wrap_o
);
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] duty_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             load;

  pwm10_settings #(.PER_W(PER_W)) u_settings (
    .clk(clk), .rst(rst), .load_i(load), .period_i(period_i),
    .duty_hi_i(duty_hi_i), .duty_lo_i(duty_lo_i),
    .last_o(last), .duty_nx_o(duty_nx)
  );

  pwm10_counter #(.PER_W(PER_W)) u_counter (
    .clk(clk), .rst(rst), .en_i(en_i), .last_i(last),
    .cnt_nx_o(cnt_nx), .load_o(load)
  );

  pwm10_compare #(.PER_W(PER_W)) u_compare (
    .clk(clk), .rst(rst), .en_i(en_i), .load_i(load),
    .cnt_nx_i(cnt_nx), .duty_nx_i(duty_nx),
    .pwm_o(pwm_o), .wrap_o(wrap_o)
  );

  // R8: reset leaves both outputs low
  a_r8_reset_low: assert property (@(posedge clk)
    rst |=> (!pwm_o && !wrap_o));
endmodule

// File: tb/pwm10_gen_tb.sv
module pwm10_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic [7:0] period_i = '0;
  logic [7:0] duty_hi_i = '0;
  logic [1:0] duty_lo_i = '0;
  logic       pwm_o, wrap_o;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;
  string force_tag = "";

  // reference state, derived from the requirements
  logic [9:0] m_cnt = '0, m_duty = '0;
  logic [7:0] m_per = '0;
  bit m_run = 0, m_pwm = 0, m_wrap = 0;

  pwm10_gen u_dut (
    .clk(clk), .rst(rst), .en_i(en_i), .period_i(period_i),
    .duty_hi_i(duty_hi_i), .duty_lo_i(duty_lo_i),
    .pwm_o(pwm_o), .wrap_o(wrap_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_per = '0; m_duty = '0; m_run = 0; m_pwm = 0; m_wrap = 0;
    end else if (!en_i) begin
      m_cnt = '0; m_run = 0; m_pwm = 0; m_wrap = 0;
    end else begin
      if (!m_run || m_cnt == {m_per, 2'b11}) begin
        m_cnt = '0; m_per = period_i; m_duty = {duty_hi_i, duty_lo_i}; m_wrap = 1;
      end else begin
        m_cnt = m_cnt + 10'd1; m_wrap = 0;
      end
      m_run = 1;
      m_pwm = (m_cnt < m_duty);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    string t;
    if (force_tag != "") t = force_tag;
    else if (!en_i) t = "R7";
    else if (m_duty == 0) t = "R4";
    else if ({22'd0, m_duty} >= 4 * ({24'd0, m_per} + 1)) t = "R3";
    else t = "R2";
    chk(pwm_o == m_pwm, t, pwm_o, m_pwm);
    chk(wrap_o == m_wrap, (force_tag != "") ? force_tag : "R6", wrap_o, m_wrap);
  end

  task automatic set(input int p, input int d);
    period_i = 8'(p); duty_hi_i = 8'(d >> 2); duty_lo_i = 2'(d);
  endtask

  task automatic measure(output int per, output int hi);
    do @(negedge clk); while (!wrap_o);
    per = 0; hi = 0;
    do begin
      if (pwm_o) hi++;
      per++;
      @(negedge clk);
    end while (!wrap_o);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int per, hi;
    repeat (3) @(negedge clk);
    chk(pwm_o == 0, "R8", pwm_o, 0);
    chk(wrap_o == 0, "R8", wrap_o, 0);
    rst = 0;
    live = 1;

    // R9: 25 % example
    set(8'h3F, 10'h040); en_i = 1;
    measure(per, hi);
    chk(per == 256, "R9", per, 256);
    chk(hi == 64, "R9", hi, 64);

    // R1: shortest and longest periods
    set(0, 1);
    measure(per, hi); measure(per, hi);
    chk(per == 4, "R1", per, 4);
    chk(hi == 1, "R2", hi, 1);
    set(8'hFF, 1023);
    measure(per, hi); measure(per, hi);
    chk(per == 1024, "R1", per, 1024);
    chk(hi == 1023, "R2", hi, 1023);

    // R3 / R4: extremes
    set(2, 12);
    measure(per, hi); measure(per, hi);
    chk(hi == 12 && per == 12, "R3", hi, 12);
    set(2, 0);
    measure(per, hi); measure(per, hi);
    chk(hi == 0, "R4", hi, 0);

    // R5: mid-period change
    force_tag = "R5";
    set(3, 8);
    measure(per, hi);
    do @(negedge clk); while (!wrap_o);
    per = 0; hi = 0;
    do begin
      if (pwm_o) hi++;
      per++;
      if (per == 5) set(1, 2);
      @(negedge clk);
    end while (!wrap_o);
    chk(per == 16, "R5", per, 16);
    chk(hi == 8, "R5", hi, 8);
    measure(per, hi);
    chk(per == 8, "R5", per, 8);
    chk(hi == 2, "R5", hi, 2);
    force_tag = "";

    // R7: disable then restart
    en_i = 0;
    repeat (3) @(negedge clk);
    chk(pwm_o == 0 && wrap_o == 0, "R7", pwm_o, 0);
    set(1, 3); en_i = 1;
    @(negedge clk);
    chk(wrap_o == 1, "R7", wrap_o, 1);

    // random mix
    void'($urandom(32'h5eed1234));
    for (int s = 0; s < 60; s++) begin
      int p, d;
      p = ($urandom % 4 == 0) ? $urandom % 256 : $urandom % 12;
      case ($urandom % 5)
        0: d = 0;
        1: d = 1023;
        default: d = $urandom % (4 * (p + 1) + 2);
      endcase
      set(p, d);
      en_i = ($urandom % 6 != 0);
      repeat (1 + $urandom % 300) @(negedge clk);
    end

    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule